// File: doc/BRIEF.md
# Low-Power One-Shot Wakeup Timer

This block is a countdown timer for waking a system from a low-power state. Its counter runs on a 32.768 kHz slow clock. Software programs it from a faster bus clock through a small register interface. Software writes a 32-bit start value into the load register. When the control register has both the single-shot and auto-start bits set, that write alone starts one countdown. When the count reaches zero, the counter stops and a sticky event flag is raised. That flag drives the interrupt line through a mask bit and is cleared by writing one to it.

Every load or control write is handed to the slow domain as a held data word plus a request toggle. The slow side answers with an acknowledge toggle. Until the acknowledge returns, which takes roughly three to four slow cycles, the `busy` output stays high and further load or control writes are dropped. Expiry events return to the bus domain as a toggle. The live count returns through per-bit synchronisers and a capture that only accepts a value seen on two successive bus cycles. Callers should stop the timer before loading a new value and should avoid load values below 8.

Top module: `wakeup_timer`

## Requirements
- R1: After reset, every readable register reads zero, and `irq` and `busy` are low.
- R2: The mask register at offset 0x10 holds bit 1 and reads back. `irq` is high exactly when the event flag and the mask bit are both set. The masked status at 0x18 shows this value in bit 1.
- R3: Writing a word with bit 1 set to offset 0x1C clears the event flag. A write there with bit 1 clear has no effect.
- R4: An accepted write to control (0x28) or load (0x24) raises `busy` on the next bus cycle. `busy` stays high until the slow domain has applied the write. Control and load writes made while `busy` is high are discarded.
- R5: Control bits read back at 0x28: bit 0 is single-shot, bit 1 is enable and bit 2 is auto-start.
- R6: A load write accepted while control has auto-start and single-shot both set starts a countdown from the written value. The count drops by one per slow clock cycle.
- R7: When the count reaches zero it stays at zero, counting stops and the event flag sets. The counter does not reload.
- R8: A load write with auto-start clear stores the value into the count but does not start counting.
- R9: A control write with enable clear freezes the count once it reaches the slow domain.
- R10: A control write with enable set resumes counting from the frozen count, and the timer then expires as usual.
- R11: Reading offset 0x20 returns the slow-domain count. The value read lags the live count by at most about two slow cycles.
- R12: The load value uses all 32 bits, so values up to 0xFFFFFFFF are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| slow_clk | input | 1 | 32.768 kHz countdown clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | High for a write, low for a read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected offset |
| busy | output | 1 | A load or control write is still crossing into the slow domain |
| irq | output | 1 | Masked expiry interrupt |

## Verification
On every bus cycle, the assertions check the following: `irq` is never high without the mask bit, the event flag stays set until a clear write, a clear write removes the flag, and an accepted control write raises `busy` with the control value held steady while `busy` is high. Other behaviour depends on the slow clock and on the crossing latency, so only the bench scenarios can show it. This covers the count dropping at the slow rate, expiry and the absence of reload, freezing and resuming, load without auto-start, discarded writes while busy, and a full 32-bit load.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int CTRL_W   = 3;
  localparam int IRQ_BIT  = 1;

  localparam int CTL_SINGLE = 0;
  localparam int CTL_ENABLE = 1;
  localparam int CTL_AUTO   = 2;

  localparam logic [ADDR_W-1:0] OFS_MASK = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h28;

  typedef struct packed {
    logic              is_ctrl;
    logic [DATA_W-1:0] data;
  } xfer_t;
endpackage

// File: rtl/wkt_rst_sync.sv
module wkt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_o = chain_q[1];
endmodule

// File: rtl/wkt_sync.sv
module wkt_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wkt_bus_regs.sv
module wkt_bus_regs
  import wkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              irq,
  output xfer_t             xfer_o,
  output logic              req_o,
  input  logic              ack_i,
  input  logic              expire_i,
  input  logic [DATA_W-1:0] count_i,
  output logic              mask_o,
  output logic              raw_o,
  output logic              expire_evt_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic              req_q, req_d;
  xfer_t             xfer_q, xfer_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              mask_q, mask_d;
  logic              raw_q, raw_d;
  logic              exp_prev_q;
  logic [DATA_W-1:0] cnt_prev_q, cnt_rd_q, cnt_rd_d;

  logic wr_hit, acc_ctrl, acc_load, clr_hit, evt;

  always_comb begin
    wr_hit   = sel & wr;
    busy     = req_q ^ ack_i;
    acc_ctrl = wr_hit && (addr == OFS_CTRL) && !busy;
    acc_load = wr_hit && (addr == OFS_LOAD) && !busy;
    clr_hit  = wr_hit && (addr == OFS_CLR) && wdata[IRQ_BIT];
    evt      = expire_i ^ exp_prev_q;

    req_d  = req_q ^ (acc_ctrl | acc_load);
    xfer_d = xfer_q;
    if (acc_ctrl | acc_load) begin
      xfer_d.is_ctrl = acc_ctrl;
      xfer_d.data    = wdata;
    end
    ctrl_d = acc_ctrl ? wdata[CTRL_W-1:0] : ctrl_q;
    mask_d = (wr_hit && (addr == OFS_MASK)) ? wdata[IRQ_BIT] : mask_q;

    if (evt)          raw_d = 1'b1;
    else if (clr_hit) raw_d = 1'b0;
    else              raw_d = raw_q;

    cnt_rd_d = (count_i == cnt_prev_q) ? count_i : cnt_rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      xfer_q     <= '0;
      ctrl_q     <= '0;
      mask_q     <= 1'b0;
      raw_q      <= 1'b0;
      exp_prev_q <= 1'b0;
      cnt_prev_q <= '0;
      cnt_rd_q   <= '0;
    end else begin
      req_q      <= req_d;
      xfer_q     <= xfer_d;
      ctrl_q     <= ctrl_d;
      mask_q     <= mask_d;
      raw_q      <= raw_d;
      exp_prev_q <= expire_i;
      cnt_prev_q <= count_i;
      cnt_rd_q   <= cnt_rd_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_MASK: rdata[IRQ_BIT]    = mask_q;
      OFS_STAT: rdata[IRQ_BIT]    = raw_q & mask_q;
      OFS_CNT:  rdata             = cnt_rd_q;
      OFS_CTRL: rdata[CTRL_W-1:0] = ctrl_q;
      default:  rdata             = '0;
    endcase
  end

  assign irq          = raw_q & mask_q;
  assign xfer_o       = xfer_q;
  assign req_o        = req_q;
  assign mask_o       = mask_q;
  assign raw_o        = raw_q;
  assign expire_evt_o = evt;
  assign ctrl_o       = ctrl_q;
endmodule

// File: rtl/wkt_slow_core.sv
module wkt_slow_core
  import wkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  xfer_t             xfer_i,
  output logic              ack_o,
  output logic              expire_o,
  output logic [DATA_W-1:0] count_o
);
  logic              req_prev_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              run_q, run_d;
  logic              exp_q, exp_d;
  logic              cmd;

  always_comb begin
    cmd    = req_i ^ req_prev_q;
    ctrl_d = ctrl_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    exp_d  = exp_q;
    if (cmd && xfer_i.is_ctrl) begin
      ctrl_d = xfer_i.data[CTRL_W-1:0];
      run_d  = xfer_i.data[CTL_ENABLE] && (cnt_q != '0);
    end else if (cmd) begin
      cnt_d = xfer_i.data;
      if (ctrl_q[CTL_AUTO] && ctrl_q[CTL_SINGLE]) run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q <= DATA_W'(1)) begin
        cnt_d = '0;
        run_d = 1'b0;
        exp_d = ~exp_q;
      end else begin
        cnt_d = cnt_q - DATA_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= 1'b0;
      ctrl_q     <= '0;
      cnt_q      <= '0;
      run_q      <= 1'b0;
      exp_q      <= 1'b0;
    end else begin
      req_prev_q <= req_i;
      ctrl_q     <= ctrl_d;
      cnt_q      <= cnt_d;
      run_q      <= run_d;
      exp_q      <= exp_d;
    end
  end

  assign ack_o    = req_prev_q;
  assign expire_o = exp_q;
  assign count_o  = cnt_q;
endmodule

// File: rtl/wakeup_timer.sv
module wakeup_timer
  import wkt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              slow_clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              irq
);
  logic              bus_rst_n, slow_rst_n;
  xfer_t             xfer;
  logic              req_tgl, req_slow;
  logic              ack_tgl, exp_tgl;
  logic [1:0]        back_sync;
  logic [DATA_W-1:0] count_slow, count_bus;
  logic              mask_bit, raw_flag, expire_evt;
  logic [CTRL_W-1:0] ctrl_val;

  wkt_rst_sync u_rst_bus  (.clk(clk),      .arst_n(rst_n), .rst_n_o(bus_rst_n));
  wkt_rst_sync u_rst_slow (.clk(slow_clk), .arst_n(rst_n), .rst_n_o(slow_rst_n));

  wkt_bus_regs u_regs (
    .clk(clk), .rst_n(bus_rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .irq(irq),
    .xfer_o(xfer), .req_o(req_tgl), .ack_i(back_sync[0]), .expire_i(back_sync[1]),
    .count_i(count_bus), .mask_o(mask_bit), .raw_o(raw_flag),
    .expire_evt_o(expire_evt), .ctrl_o(ctrl_val)
  );

  wkt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(slow_clk), .rst_n(slow_rst_n), .d(req_tgl), .q(req_slow)
  );

  wkt_slow_core u_core (
    .clk(slow_clk), .rst_n(slow_rst_n), .req_i(req_slow), .xfer_i(xfer),
    .ack_o(ack_tgl), .expire_o(exp_tgl), .count_o(count_slow)
  );

  wkt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_back_sync (
    .clk(clk), .rst_n(bus_rst_n), .d({exp_tgl, ack_tgl}), .q(back_sync)
  );

  wkt_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(bus_rst_n), .d(count_slow), .q(count_bus)
  );
endmodule

// File: rtl/wkt_checker.sv
module wkt_checker
  import wkt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              busy,
  input logic              irq,
  input logic              mask_bit,
  input logic              raw_flag,
  input logic [CTRL_W-1:0] ctrl_val,
  input logic              expire_evt
);
  logic clr_wr, ctrl_acc;
  assign clr_wr   = bus_sel && bus_wr && (bus_addr == OFS_CLR) && bus_wdata[IRQ_BIT];
  assign ctrl_acc = bus_sel && bus_wr && (bus_addr == OFS_CTRL) && !busy;

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_bit); // R2
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire_evt) |=> !raw_flag); // R3
  AST_CTRL_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_acc |=> busy); // R4
  AST_CTRL_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl_val)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_flag && !clr_wr) |=> raw_flag); // R7
endmodule

bind wakeup_timer wkt_checker u_chk (
  .clk(clk), .rst_n(bus_rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy), .irq(irq),
  .mask_bit(mask_bit), .raw_flag(raw_flag), .ctrl_val(ctrl_val),
  .expire_evt(expire_evt)
);

// File: tb/wakeup_timer_test.sv
`timescale 1ns/1ps
module wakeup_timer_test;
  logic        clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        busy, irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit running = 1'b0;

  // behavioural model state
  int m_mask = 0;
  int m_ctrl = 0;

  always #10 clk = ~clk;
  initial begin
    #7;
    forever #165 slow_clk = ~slow_clk;
  end

  wakeup_timer uut (
    .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model: irq only with mask set (R2)
  always @(negedge clk) begin
    #2;
    if (running) check(!(irq && m_mask == 0), "R2 irq without mask", {31'b0, irq}, 32'h0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    if (a == 6'h10 && d[1]) m_mask = 1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (a == 6'h10 && !d[1]) m_mask = 0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(posedge slow_clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, a, b, c;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_slow(4);
    running = 1'b1;

    // R1 reset state
    bus_read(6'h28, v); check(v == 0, "R1 ctrl reset", v, 0);
    bus_read(6'h10, v); check(v == 0, "R1 mask reset", v, 0);
    bus_read(6'h18, v); check(v == 0, "R1 status reset", v, 0);
    bus_read(6'h20, v); check(v == 0, "R1 count reset", v, 0);
    check(irq == 0 && busy == 0, "R1 irq/busy reset", {30'b0, irq, busy}, 0);

    // R2 mask readback
    bus_write(6'h10, 32'h2);
    bus_read(6'h10, v); check(v == 32'h2, "R2 mask readback", v, 32'h2);
    bus_write(6'h10, 32'h0);

    // R4 busy and discarded writes, R5 control readback
    bus_write(6'h28, 32'h5);
    check(busy == 1, "R4 busy after control write", {31'b0, busy}, 1);
    bus_write(6'h28, 32'h2);
    bus_write(6'h24, 32'd999);
    wait_idle();
    m_ctrl = 5;
    bus_read(6'h28, v); check(v == 32'h5, "R5 R4 control readback", v, 32'h5);
    wait_slow(6);
    bus_read(6'h20, v); check(v == 0, "R4 load while busy discarded", v, 0);

    // R6 auto-start load and countdown rate, R11 count readback
    bus_write(6'h24, 32'd20);
    check(busy == 1, "R4 busy after load write", {31'b0, busy}, 1);
    wait_idle();
    bus_read(6'h20, a); check(a >= 17 && a <= 20, "R11 count after load", a, 20);
    wait_slow(5);
    bus_read(6'h20, b); check(a - b >= 4 && a - b <= 6, "R6 countdown rate", a - b, 5);

    // R7 expiry with mask clear, then mask set
    wait_slow(25);
    check(irq == 0, "R2 irq masked", {31'b0, irq}, 0);
    bus_read(6'h18, v); check(v == 0, "R2 status masked", v, 0);
    bus_read(6'h20, v); check(v == 0, "R7 count stops at zero", v, 0);
    bus_write(6'h10, 32'h2);
    check(irq == 1, "R2 R7 irq after mask", {31'b0, irq}, 1);
    bus_read(6'h18, v); check(v == 32'h2, "R2 status bit", v, 32'h2);
    wait_slow(30);
    bus_read(6'h20, v); check(v == 0, "R7 no reload", v, 0);

    // R3 clear
    bus_write(6'h1C, 32'h1);
    check(irq == 1, "R3 clear without bit 1 ignored", {31'b0, irq}, 1);
    bus_write(6'h1C, 32'h2);
    check(irq == 0, "R3 clear drops irq", {31'b0, irq}, 0);

    // R9 freeze
    bus_write(6'h24, 32'd200);
    wait_idle();
    wait_slow(10);
    bus_write(6'h28, 32'h4);
    wait_idle();
    wait_slow(1);
    bus_read(6'h20, a);
    wait_slow(10);
    bus_read(6'h20, b);
    check(a == b && a > 170 && a < 200, "R9 count frozen", b, a);
    check(irq == 0, "R9 no irq while frozen", {31'b0, irq}, 0);

    // R10 resume
    bus_write(6'h28, 32'h6);
    wait_idle();
    wait_slow(10);
    bus_read(6'h20, c);
    check(a - c >= 8 && a - c <= 14, "R10 resume counting", a - c, 10);
    wait_slow(int'(c) + 6);
    check(irq == 1, "R10 R7 expiry after resume", {31'b0, irq}, 1);
    bus_write(6'h1C, 32'h2);

    // R8 load without auto-start
    bus_write(6'h28, 32'h0);
    wait_idle();
    bus_write(6'h24, 32'd50);
    wait_idle();
    wait_slow(10);
    bus_read(6'h20, v); check(v == 50, "R8 load holds", v, 50);
    check(irq == 0, "R8 no expiry", {31'b0, irq}, 0);

    // R12 full-width load
    bus_write(6'h28, 32'h5);
    wait_idle();
    bus_write(6'h24, 32'hFFFF_FFF0);
    wait_idle();
    wait_slow(3);
    bus_read(6'h20, v);
    check(v >= 32'hFFFF_FFE0 && v < 32'hFFFF_FFF0, "R12 wide count", v, 32'hFFFF_FFEC);
    bus_write(6'h28, 32'h0);
    wait_idle();

    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule